// File: doc/BRIEF.md
# Operand Trace Serializer

This block watches the operand transfers a processor core makes and sends a chosen subset of them out over a narrow trace port, four bits per trace clock. Each offered transfer carries a data value, an operand size and a direction flag. A two-bit capture mode decides which directions are sent. A captured transfer goes out as a frame. The frame starts with one size marker nibble. The data nibbles follow, least significant first, and their number is set by the operand size.

When no frame is being sent, the trace port shows `0000` and `busy` is low. A transfer captured while a frame is under way waits in a one-entry holding slot. It goes out directly after the current frame, with no idle cycle between the frames. A further capture that arrives while the slot is occupied is discarded. A sticky overflow flag records the loss and stays set until reset.

Top module: `optrace_ser`

## Requirements
- R1: After synchronous active-low reset, `trace_nib` is `0000`, and `busy` and `overflow` are both low.
- R2: `cap_mode` selects the transfers that are captured (`xfer_write`=1 means write, 0 means read): `00` captures none, `01` captures writes only, `10` captures reads only, `11` captures both.
- R3: `xfer_size` is `00` byte, `01` word, `10` long. The code `11` is reserved, and a transfer that carries it is never captured.
- R4: A transfer captured at a clock edge while the block is idle shows its size marker on `trace_nib` in the following cycle: `1001` for byte, `1010` for word, `1011` for long.
- R5: The data nibbles follow the marker, one per cycle, least significant nibble first: 2 nibbles for a byte, 4 for a word, 8 for a long. A frame therefore lasts 3, 5 or 9 cycles.
- R6: `busy` is high in exactly the cycles in which a marker or a data nibble is shown. When `busy` is low, `trace_nib` is `0000`.
- R7: A transfer captured while a frame is in progress and the slot is empty is held. Its marker follows the last data nibble of the current frame in the very next cycle.
- R8: A transfer captured while a frame is in progress and the slot is full is discarded. `overflow` then goes high and stays high until reset.
- R9: A transfer captured in the cycle that shows the last data nibble, with the slot empty, starts its marker in the next cycle, back to back.
- R10: Data bits above the operand size never reach `trace_nib`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Trace clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_mode | input | 2 | Capture mode: bit 0 enables writes, bit 1 enables reads |
| xfer_valid | input | 1 | A transfer is offered in this cycle |
| xfer_data | input | DATA_W | Operand value |
| xfer_size | input | 2 | Operand size code |
| xfer_write | input | 1 | 1 for a write transfer, 0 for a read |
| trace_nib | output | 4 | Trace nibble output |
| busy | output | 1 | A frame is being sent |
| overflow | output | 1 | Sticky flag: a captured transfer was lost |

## Verification
The bench builds the block with the default `DATA_W` of 32. With that width, all three operand sizes give frames of different length: 2, 4 and 8 data nibbles. It also lets filler bits above the byte and word sizes be checked for leakage. The short byte frame makes it easy to land a new offer exactly on the last nibble. The long frame leaves room to fill the slot and then overrun it in the middle of a frame.

// File: rtl/optrace_pkg.sv
// Shared types for the operand trace serializer.
// Assumes a fixed four-bit trace nibble.
package optrace_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } opsize_e;

    // Marker nibble shown ahead of the data: byte 1001, word 1010, long 1011.
    function automatic logic [NIB_W-1:0] size_marker(opsize_e s);
        return 4'(4'b1001 + {2'b00, s});
    endfunction

endpackage

// File: rtl/optrace_filter.sv
// Capture filter: decides whether an offered transfer is taken.
// Assumes mode bit 0 enables writes, mode bit 1 enables reads,
// and that the reserved size code is never taken.
module optrace_filter
    import optrace_pkg::*;
(
    input  logic       valid,
    input  opsize_e    size,
    input  logic       write,
    input  logic [1:0] mode,
    output logic       take
);

    logic dir_ok;

    // Direction match against the capture mode.
    always_comb begin
        dir_ok = write ? mode[0] : mode[1];
        take   = valid && dir_ok && (size != SZ_RSVD);
    end

endmodule

// File: rtl/optrace_slot.sv
// Single-entry holding slot for a captured transfer that waits for the engine.
// Assumes the caller asserts put only when the slot is empty or is being emptied.
module optrace_slot
    import optrace_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              put,
    input  logic [DATA_W-1:0] put_data,
    input  opsize_e           put_size,
    input  logic              drain,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output opsize_e           size
);

    // Slot occupancy and contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
            size <= SZ_BYTE;
        end else if (put) begin
            full <= 1'b1;
            data <= put_data;
            size <= put_size;
        end else if (drain) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/optrace_shift.sv
// Frame engine: on load, shows the size marker, then shifts out the data one
// nibble per cycle, least significant first. Assumes load is only raised
// while idle or in the last data nibble cycle (last high).
module optrace_shift
    import optrace_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] ld_data,
    input  opsize_e           ld_size,
    output logic [NIB_W-1:0]  nib,
    output logic              busy,
    output logic              last
);

    localparam int LONG_NIBS = DATA_W / NIB_W;
    localparam int WORD_NIBS = LONG_NIBS / 2;
    localparam int BYTE_NIBS = LONG_NIBS / 4;
    localparam int CNT_W     = $clog2(LONG_NIBS + 1);

    logic [DATA_W-1:0] sh;
    logic [CNT_W-1:0]  rem;

    // Number of data nibbles in a frame of the given size.
    function automatic logic [CNT_W-1:0] nib_total(opsize_e s);
        case (s)
            SZ_BYTE: return CNT_W'(BYTE_NIBS);
            SZ_WORD: return CNT_W'(WORD_NIBS);
            default: return CNT_W'(LONG_NIBS);
        endcase
    endfunction

    // Marker load, nibble shift and return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nib  <= '0;
            busy <= 1'b0;
            rem  <= '0;
            sh   <= '0;
        end else if (load) begin
            nib  <= size_marker(ld_size);
            sh   <= ld_data;
            rem  <= nib_total(ld_size);
            busy <= 1'b1;
        end else if (busy && rem != '0) begin
            nib <= sh[NIB_W-1:0];
            sh  <= sh >> NIB_W;
            rem <= rem - CNT_W'(1);
        end else begin
            nib  <= '0;
            busy <= 1'b0;
        end
    end

    // Final data nibble of the frame is on the output.
    always_comb last = busy && (rem == '0);

endmodule

// File: rtl/optrace_ser.sv
// Operand trace serializer top: filters offered transfers, holds at most one
// waiting transfer, and drives the nibble engine. Assumes the inputs are
// synchronous to clk.
module optrace_ser
    import optrace_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cap_mode,
    input  logic              xfer_valid,
    input  logic [DATA_W-1:0] xfer_data,
    input  logic [1:0]        xfer_size,
    input  logic              xfer_write,
    output logic [3:0]        trace_nib,
    output logic              busy,
    output logic              overflow
);

    logic              cap;
    logic              last;
    logic              free;
    logic              slot_full;
    logic [DATA_W-1:0] slot_data;
    opsize_e           slot_size;
    logic              drain;
    logic              start_in;
    logic              load;
    logic              put;
    logic              drop;
    logic [DATA_W-1:0] ld_data;
    opsize_e           ld_size;
    opsize_e           in_size;

    assign in_size = opsize_e'(xfer_size);

    optrace_filter u_filter (
        .valid (xfer_valid),
        .size  (in_size),
        .write (xfer_write),
        .mode  (cap_mode),
        .take  (cap)
    );

    // Engine hand-off: the slot has priority, then a direct start.
    always_comb begin
        free     = !busy || last;
        drain    = free && slot_full;
        start_in = free && !slot_full && cap;
        load     = drain || start_in;
        put      = cap && !start_in && (!slot_full || drain);
        drop     = cap && !start_in && !put;
        ld_data  = slot_full ? slot_data : xfer_data;
        ld_size  = slot_full ? slot_size : in_size;
    end

    optrace_slot #(.DATA_W(DATA_W)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .put      (put),
        .put_data (xfer_data),
        .put_size (in_size),
        .drain    (drain),
        .full     (slot_full),
        .data     (slot_data),
        .size     (slot_size)
    );

    optrace_shift #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .ld_data (ld_data),
        .ld_size (ld_size),
        .nib     (trace_nib),
        .busy    (busy),
        .last    (last)
    );

    // Sticky record of a lost transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)    overflow <= 1'b0;
        else if (drop) overflow <= 1'b1;
    end

endmodule

// File: rtl/optrace_chk.sv
// Port-level property checker for optrace_ser, attached by bind.
module optrace_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cap_mode,
    input logic       xfer_valid,
    input logic [1:0] xfer_size,
    input logic       xfer_write,
    input logic [3:0] trace_nib,
    input logic       busy,
    input logic       overflow
);

    logic wanted;
    assign wanted = xfer_valid && (xfer_size != 2'b11) &&
                    ((xfer_write && cap_mode[0]) || (!xfer_write && cap_mode[1]));

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> trace_nib == 4'b0000);

    assert_marker_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (trace_nib == 4'b1001 || trace_nib == 4'b1010 || trace_nib == 4'b1011));

    assert_idle_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wanted) |=> busy);

    assert_mode_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cap_mode == 2'b00) |=> !busy);

    assert_rsvd_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && xfer_size == 2'b11) |=> !busy);

    assert_sticky_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    assert_ovf_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(busy && wanted));

endmodule

bind optrace_ser optrace_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_mode   (cap_mode),
    .xfer_valid (xfer_valid),
    .xfer_size  (xfer_size),
    .xfer_write (xfer_write),
    .trace_nib  (trace_nib),
    .busy       (busy),
    .overflow   (overflow)
);

// File: tb/tb_optrace_ser.sv
`timescale 1ns/1ps
module tb_optrace_ser;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cap_mode = 2'b11;
    logic        xfer_valid = 1'b0;
    logic [31:0] xfer_data = '0;
    logic [1:0]  xfer_size = 2'b00;
    logic        xfer_write = 1'b0;
    logic [3:0]  trace_nib;
    logic        busy;
    logic        overflow;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    optrace_ser dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_mode   (cap_mode),
        .xfer_valid (xfer_valid),
        .xfer_data  (xfer_data),
        .xfer_size  (xfer_size),
        .xfer_write (xfer_write),
        .trace_nib  (trace_nib),
        .busy       (busy),
        .overflow   (overflow)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Advance to the next falling edge and withdraw any offer.
    task automatic step();
        @(negedge clk);
        xfer_valid = 1'b0;
    endtask

    task automatic offer(input logic [31:0] d, input logic [1:0] s, input logic w);
        xfer_valid = 1'b1;
        xfer_data  = d;
        xfer_size  = s;
        xfer_write = w;
    endtask

    function automatic int nib_count(input logic [1:0] s);
        return (s == 2'b00) ? 2 : (s == 2'b01) ? 4 : 8;
    endfunction

    // Checks the marker now on the port, then every data nibble; returns at the last one.
    task automatic expect_frame(input logic [31:0] d, input logic [1:0] s);
        logic [3:0] mk;
        mk = 4'(4'h9 + {2'b00, s});
        chk(trace_nib == mk, "R4 marker", 32'(trace_nib), 32'(mk));
        chk(busy == 1'b1, "R6 busy on marker", 32'(busy), 1);
        for (int i = 0; i < nib_count(s); i++) begin
            logic [3:0] e;
            step();
            e = 4'((d >> (4 * i)) & 32'hF);
            chk(trace_nib == e, "R5 data nibble", 32'(trace_nib), 32'(e));
            chk(busy == 1'b1, "R6 busy on data", 32'(busy), 1);
        end
    endtask

    task automatic t_reset();
        chk(trace_nib == 4'h0, "R1 nib", 32'(trace_nib), 0);
        chk(busy == 1'b0, "R1 busy", 32'(busy), 0);
        chk(overflow == 1'b0, "R1 overflow", 32'(overflow), 0);
    endtask

    task automatic t_modes();
        for (int m = 0; m < 4; m++) begin
            for (int w = 0; w < 2; w++) begin
                logic exp;
                cap_mode = 2'(m);
                exp = (w == 1) ? cap_mode[0] : cap_mode[1];
                offer(32'h8765_4321, 2'b10, 1'(w));
                step();
                chk(busy == exp, "R2 capture filter", 32'(busy), 32'(exp));
                if (exp) begin
                    expect_frame(32'h8765_4321, 2'b10);
                    step();
                end
                chk(busy == 1'b0 && trace_nib == 4'h0, "R6 idle after frame", 32'(trace_nib), 0);
            end
        end
        cap_mode = 2'b11;
    endtask

    task automatic t_sizes();
        offer(32'hFFFF_FF5A, 2'b00, 1'b0);
        step();
        expect_frame(32'h0000_005A, 2'b00);  // R10 upper bits absent
        step();
        chk(busy == 1'b0, "R5 byte length", 32'(busy), 0);
        offer(32'hEEEE_C3B7, 2'b01, 1'b1);
        step();
        expect_frame(32'h0000_C3B7, 2'b01);  // R10 upper bits absent
        step();
        chk(busy == 1'b0, "R5 word length", 32'(busy), 0);
        offer(32'h1234_5678, 2'b11, 1'b1);
        step();
        chk(busy == 1'b0 && trace_nib == 4'h0, "R3 reserved size ignored", 32'(busy), 0);
        step();
        chk(busy == 1'b0, "R3 reserved size stays ignored", 32'(busy), 0);
    endtask

    task automatic t_pending();
        offer(32'hA1B2_C3D4, 2'b10, 1'b1);
        step();
        offer(32'h0000_9E6F, 2'b01, 1'b0);   // R7 offered mid-frame
        expect_frame(32'hA1B2_C3D4, 2'b10);
        step();
        expect_frame(32'h0000_9E6F, 2'b01);  // R7 no gap
        step();
        chk(busy == 1'b0, "R7 idle after held frame", 32'(busy), 0);
    endtask

    task automatic t_back2back();
        offer(32'h0000_00C4, 2'b00, 1'b1);
        step();
        expect_frame(32'h0000_00C4, 2'b00);
        offer(32'h0000_00E2, 2'b00, 1'b1);   // R9 on last nibble
        step();
        expect_frame(32'h0000_00E2, 2'b00);
        step();
        chk(busy == 1'b0, "R9 idle after second frame", 32'(busy), 0);
        chk(overflow == 1'b0, "R9 no overflow", 32'(overflow), 0);
    endtask

    task automatic t_overflow();
        offer(32'h7654_3210, 2'b10, 1'b1);
        step();                               // marker of A
        offer(32'h0000_5AA5, 2'b01, 1'b0);    // B into slot
        step();                               // nibble 0
        chk(trace_nib == 4'h0, "R5 nibble 0", 32'(trace_nib), 0);
        offer(32'hDEAD_BEEF, 2'b10, 1'b1);    // C: slot full
        step();                               // nibble 1
        chk(trace_nib == 4'h1, "R5 nibble 1", 32'(trace_nib), 1);
        chk(overflow == 1'b1, "R8 overflow set", 32'(overflow), 1);
        for (int i = 2; i < 8; i++) begin
            step();
            chk(trace_nib == 4'(i), "R5 nibble", 32'(trace_nib), 32'(i));
        end
        step();
        expect_frame(32'h0000_5AA5, 2'b01);
        step();
        chk(busy == 1'b0, "R8 dropped transfer not sent", 32'(busy), 0);
        chk(overflow == 1'b1, "R8 overflow sticky", 32'(overflow), 1);
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
        chk(overflow == 1'b0, "R1 overflow cleared by reset", 32'(overflow), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_modes();
        t_sizes();
        t_pending();
        t_back2back();
        t_overflow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule